// File: doc/BRIEF.md
# Colour Lookup Table Write Sequencer

This block is the processor-side write port of a 256-entry colour lookup table. Each entry holds one byte of red, one of green and one of blue. Software first sets an entry pointer. It then streams colour bytes into a single data register. A rolling component counter steers each byte to red, then green, then blue. After blue, the pointer moves on to the next entry without any further action from software. This lets a whole table be loaded with one pointer write and a run of data writes.

A data write is either one byte or one 32-bit word. A word is unpacked into four byte stores, taken from the most significant byte down to the least significant byte. The block performs these stores over four clock cycles and holds `busy` high until they are done. The bus master must keep retrying while `busy` is high, because any write presented during that time is dropped.

A scan-out path reads any entry through a separate combinational lookup port. A sticky change flag tells the display side that the table was modified, so the whole screen needs redrawing. The display side clears the flag with an acknowledge pulse.

Top module: `clut_write_seq`

## Requirements
- R1: After reset all 768 table bytes read back as zero at the lookup port, the component counter points at red, `busy` is low and `tableChanged` is high.
- R2: A write accepted at offset 0 loads the entry pointer from `busWdata[7:0]` and returns the component counter to red, even part-way through an entry.
- R3: Successive byte stores into the current entry go to red (component 0), then green (component 1), then blue (component 2).
- R4: The store of blue returns the counter to red and advances the pointer by one, modulo 256, so entry 255 is followed by entry 0.
- R5: A data write at offset 4 with `busWide`=1 performs four byte stores in the order bits 31:24, 23:16, 15:8, 7:0, one per cycle, with `busy` high for exactly four cycles. With `busWide`=0 it performs one store of `busWdata[7:0]`, with `busy` high for one cycle.
- R6: A write presented while `busy` is high has no effect. A write to any offset other than 0 or 4 has no effect.
- R7: `busRdata` is zero for every register.
- R8: An accepted data write sets `tableChanged`, and `changeAck` clears it. If both occur in the same cycle, the set wins. A pointer write leaves the flag unchanged.
- R9: `lookupRgb` is combinational on `lookupIdx` and returns red in bits 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register byte offset: 0 = entry pointer, 4 = colour data |
| busWrite | input | 1 | Write strobe, accepted when `busy` is low |
| busWide | input | 1 | 1 = 32-bit access, 0 = byte access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, always zero |
| busy | output | 1 | Byte stores still pending; further writes are dropped |
| changeAck | input | 1 | Clears `tableChanged` |
| tableChanged | output | 1 | Table modified since the last acknowledge |
| lookupIdx | input | 8 | Scan-out entry select |
| lookupRgb | output | 24 | Selected entry as {red, green, blue} |

## Verification
On every cycle, the embedded assertions check the following:
- every store lands in the addressed table byte;
- the component counter never leaves the range 0 to 2, and it steps from red to green and from blue back to red with the pointer incremented;
- a pointer write loads the pointer and resets the counter;
- a word write raises `busy`;
- an accepted data write sets the change flag.

Some behaviour shows only in the bench's scenarios:
- the most-significant-first byte order inside a word;
- the exact four-cycle and one-cycle `busy` windows;
- pointer wrap from 255 to 0 in the middle of a word;
- writes dropped during `busy` or sent to unused offsets;
- the full table contents after a long random mix of pointer, byte and word writes.

// File: rtl/clut_pkg.sv
package clut_pkg;
  parameter int IdxW = 8;
  localparam int Entries = 1 << IdxW;
  localparam int ByteW = 8;
  localparam int CompW = 2;
  localparam int NumComp = 3;

  // Strobes from the sequencer to the table storage.
  typedef struct packed {
    logic             storeEn;
    logic [CompW-1:0] comp;
    logic [IdxW-1:0]  entry;
    logic [ByteW-1:0] value;
  } store_t;
endpackage

// File: rtl/clut_seq_ctrl.sv
module clut_seq_ctrl
  import clut_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int IDX_OFFSET  = 0,
  parameter int DATA_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              changeAck,
  output logic              busy,
  output logic              tableChanged,
  output store_t            storeOut
);
  localparam int Bytes = DATA_W / ByteW;
  localparam int CntW  = $clog2(Bytes + 1);
  localparam logic [CompW-1:0] LastComp = CompW'(NumComp - 1);

  logic [IdxW-1:0]   entryPtr;
  logic [CompW-1:0]  phase;
  logic [CntW-1:0]   pendCnt;
  logic [DATA_W-1:0] shiftReg;
  logic              acceptIdx;
  logic              acceptData;

  assign busy       = (pendCnt != '0);
  assign acceptIdx  = busWrite && !busy && (busAddr == ADDR_W'(IDX_OFFSET));
  assign acceptData = busWrite && !busy && (busAddr == ADDR_W'(DATA_OFFSET));

  always_comb begin
    storeOut.storeEn = busy;
    storeOut.comp    = phase;
    storeOut.entry   = entryPtr;
    storeOut.value   = shiftReg[DATA_W-1 -: ByteW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryPtr <= '0;
      phase    <= '0;
      pendCnt  <= '0;
      shiftReg <= '0;
    end else if (busy) begin
      shiftReg <= shiftReg << ByteW;
      pendCnt  <= pendCnt - 1'b1;
      if (phase == LastComp) begin
        phase    <= '0;
        entryPtr <= entryPtr + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end else if (acceptIdx) begin
      entryPtr <= busWdata[IdxW-1:0];
      phase    <= '0;
    end else if (acceptData) begin
      if (busWide) begin
        shiftReg <= busWdata;
        pendCnt  <= CntW'(Bytes);
      end else begin
        shiftReg <= {busWdata[ByteW-1:0], {(DATA_W-ByteW){1'b0}}};
        pendCnt  <= CntW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           tableChanged <= 1'b1;
    else if (acceptData) tableChanged <= 1'b1;
    else if (changeAck)  tableChanged <= 1'b0;
  end

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LastComp);
  assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase == '0) |=> (phase == CompW'(1)));
  assert_blue_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase == LastComp) |=> (phase == '0 && entryPtr == $past(entryPtr) + 1'b1));
  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptIdx |=> (phase == '0 && entryPtr == $past(busWdata[IdxW-1:0])));
  assert_wide_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptData && busWide) |=> busy);
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    acceptData |=> tableChanged);
endmodule

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  store_t          storeIn,
  input  logic [IdxW-1:0] lookupIdx,
  output logic [NumComp*ByteW-1:0] lookupRgb
);
  logic [ByteW-1:0] tab [NumComp][Entries];

  for (genvar c = 0; c < NumComp; c++) begin : g_comp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < Entries; e++) tab[c][e] <= '0;
      end else if (storeIn.storeEn && storeIn.comp == CompW'(c)) begin
        tab[c][storeIn.entry] <= storeIn.value;
      end
    end
    // Red sits in the top byte, blue in the bottom byte.
    assign lookupRgb[(NumComp-c)*ByteW-1 -: ByteW] = tab[c][lookupIdx];
  end

  assert_store_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    storeIn.storeEn |=> tab[$past(storeIn.comp)][$past(storeIn.entry)] == $past(storeIn.value));
endmodule

// File: rtl/clut_write_seq.sv
module clut_write_seq
  import clut_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int IDX_OFFSET  = 0,
  parameter int DATA_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busy,
  input  logic              changeAck,
  output logic              tableChanged,
  input  logic [IdxW-1:0]   lookupIdx,
  output logic [NumComp*ByteW-1:0] lookupRgb
);
  store_t storeBus;

  // Both registers are write-only; reads return zero.
  assign busRdata = '0;

  clut_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_OFFSET(IDX_OFFSET), .DATA_OFFSET(DATA_OFFSET)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWide(busWide), .busWdata(busWdata), .changeAck(changeAck),
    .busy(busy), .tableChanged(tableChanged), .storeOut(storeBus)
  );

  clut_table table_i (
    .clk(clk), .rstN(rstN), .storeIn(storeBus),
    .lookupIdx(lookupIdx), .lookupRgb(lookupRgb)
  );
endmodule

// File: tb/clut_write_seq_tb_top.sv
`timescale 1ns/1ps
module clut_write_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busWide = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busy;
  logic        changeAck = 1'b0;
  logic        tableChanged;
  logic [7:0]  lookupIdx = '0;
  logic [23:0] lookupRgb;

  int checks = 0;
  int fails = 0;
  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] mIdx = '0;
  int mPhase = 0;

  always #10 clk = ~clk;

  clut_write_seq dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWide(busWide), .busWdata(busWdata), .busRdata(busRdata), .busy(busy),
    .changeAck(changeAck), .tableChanged(tableChanged),
    .lookupIdx(lookupIdx), .lookupRgb(lookupRgb)
  );

  function automatic logic [23:0] expRgb(input logic [7:0] i);
    return {mr[i], mg[i], mb[i]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelStore(input logic [7:0] b);
    case (mPhase)
      0: mr[mIdx] = b;
      1: mg[mIdx] = b;
      default: mb[mIdx] = b;
    endcase
    if (mPhase == 2) begin mPhase = 0; mIdx = mIdx + 8'd1; end
    else mPhase++;
  endtask

  task automatic checkEntry(input string req, input logic [7:0] i);
    lookupIdx = i;
    #1;
    check(req, {8'h0, lookupRgb}, {8'h0, expRgb(i)});
  endtask

  task automatic busWr(input logic [2:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWide = w; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic wrIdx(input logic [7:0] v);
    int n;
    busWr(3'd0, 1'b0, {24'h0, v});
    waitIdle(n);
    mIdx = v; mPhase = 0;
  endtask

  task automatic wrData(input logic w, input logic [31:0] d, output int n);
    busWr(3'd4, w, d);
    waitIdle(n);
    if (w) for (int k = 3; k >= 0; k--) modelStore(d[k*8 +: 8]);
    else modelStore(d[7:0]);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int seedDummy;
    for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 flag", {31'h0, tableChanged}, 32'h1);
    checkEntry("R1 entry0", 8'd0);
    checkEntry("R1 entry128", 8'd128);
    checkEntry("R1 entry255", 8'd255);
    check("R7 rdata", busRdata, 32'h0);

    // R8: acknowledge clears, pointer write does not set
    @(negedge clk); changeAck = 1'b1; @(negedge clk); changeAck = 1'b0;
    check("R8 ack clears", {31'h0, tableChanged}, 32'h0);

    // R1/R3: first byte after reset goes to red of entry 0
    wrData(1'b0, 32'h0000_0077, n);
    check("R5 byte busy cycles", n, 1);
    checkEntry("R1 phase red after reset", 8'd0);
    check("R8 set by data", {31'h0, tableChanged}, 32'h1);
    @(negedge clk); changeAck = 1'b1; @(negedge clk); changeAck = 1'b0;

    // R2/R3: pointer then three bytes
    wrIdx(8'd5);
    check("R8 pointer leaves flag", {31'h0, tableChanged}, 32'h0);
    wrData(1'b0, 32'hFFFF_FF11, n);
    wrData(1'b0, 32'h0000_0022, n);
    wrData(1'b0, 32'h0000_0033, n);
    checkEntry("R3 rgb order", 8'd5);
    checkEntry("R4 next untouched", 8'd6);

    // R4/R5: word straddling the wrap 255 -> 0
    wrIdx(8'd255);
    wrData(1'b1, 32'hAABB_CCDD, n);
    check("R5 word busy cycles", n, 4);
    checkEntry("R5 msb first", 8'd255);
    wrData(1'b0, 32'h0000_0001, n);
    wrData(1'b0, 32'h0000_0002, n);
    checkEntry("R4 wrap to entry0", 8'd0);
    check("R9 red bits", {24'h0, lookupRgb[23:16]}, 32'hDD);

    // R2: pointer write mid-entry resets phase
    wrIdx(8'd7);
    wrData(1'b0, 32'h44, n);
    wrIdx(8'd7);
    wrData(1'b0, 32'h55, n);
    checkEntry("R2 phase reset", 8'd7);

    // R6: writes during busy dropped
    @(negedge clk);
    busAddr = 3'd4; busWide = 1'b1; busWdata = 32'h0102_0304; busWrite = 1'b1;
    @(negedge clk);
    busAddr = 3'd0; busWdata = 32'd200; busWrite = 1'b1;
    @(negedge clk);
    busAddr = 3'd4; busWide = 1'b0; busWdata = 32'h99;
    @(negedge clk);
    busWrite = 1'b0;
    waitIdle(n);
    for (int k = 3; k >= 0; k--) modelStore(8'(32'h0102_0304 >> (k*8)));
    wrData(1'b0, 32'h66, n);
    checkEntry("R6 busy drop entry7", 8'd7);
    checkEntry("R6 busy drop entry8", 8'd8);
    checkEntry("R6 no entry200", 8'd200);

    // R6: unused offset ignored
    busWr(3'd2, 1'b1, 32'hDEAD_BEEF);
    busWr(3'd6, 1'b0, 32'h0000_00EE);
    wrData(1'b0, 32'h77, n);
    checkEntry("R6 unused offset", 8'd8);
    check("R7 rdata after writes", busRdata, 32'h0);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: wrIdx(8'($urandom));
        1: wrData(1'b0, $urandom, n);
        2: begin
          wrData(1'b1, $urandom, n);
          check("R5 random word cycles", n, 4);
        end
        3: busWr(3'($urandom % 2 == 0 ? 1 : 5), 1'($urandom), $urandom);
        default: begin
          changeAck = 1'b1; @(negedge clk); changeAck = 1'b0;
          check("R8 random ack", {31'h0, tableChanged}, 32'h0);
        end
      endcase
    end
    for (int i = 0; i < 256; i++) checkEntry("R3 final table", 8'(i));

    // R1: reset clears the table again
    @(negedge clk); rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
    checkEntry("R1 cleared", 8'd5);
    checkEntry("R1 cleared", 8'd255);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule